// File: doc/BRIEF.md
# Alternating Word Pattern Generator

This block produces a serial test bit stream for link checking. A 32-bit pattern input holds two 16-bit words. In alternating mode the block sends the low word a programmable number of times, then the high word the same number of times, and starts over. In repetitive mode it sends the full 32-bit pattern over and over, and the repeat count has no effect.

One bit leaves the block on each clock edge where both the enable and the bit-clock enable are high. Each word is sent MSB first. A word-boundary strobe marks the first bit of every word, so a receiver or a testbench can align to the stream. The pattern and the repeat count are sampled when each word begins. The software can therefore rewrite them at any time without breaking the word that is being sent.

Top module: `altword_gen`

## Requirements
- R1: A synchronous active-high reset drives `ser_out` and `word_start` to 0 on the reset edge. The first bit emitted after reset is the MSB of the first repetition of the low word (repetitive mode: the MSB of the full pattern).
- R2: With `mode`=1 (alternating), the block sends `pattern[15:0]` (`rep_count`+1) times, then `pattern[31:16]` (`rep_count`+1) times, and repeats this cycle without end.
- R3: Every count value is valid. `rep_count`=00h sends each half once before switching, and `rep_count`=FFh sends each half 256 times.
- R4: Each word is sent MSB first. `ser_out` is a register that takes the next bit on every rising clock edge where `en`=1, `bit_en`=1 and `mode` is unchanged from the previous cycle.
- R5: On an edge where `en`=1 and `bit_en`=0, `ser_out` and `word_start` hold their values and the sequence does not advance.
- R6: With `mode`=0 (repetitive), all 32 bits of `pattern` are sent MSB first, over and over, and `rep_count` has no effect on the stream.
- R7: `pattern` and `rep_count` are sampled when each word begins. A change made while a word is in progress takes effect only from the next word.
- R8: On the first edge after `mode` changes (with `en`=1), no bit is emitted and both outputs become 0. The next emitted bit is the first bit of the new mode's sequence.
- R9: `word_start` is 1 exactly while `ser_out` carries the first bit of a word. Word starts fall every 16 emitted bits in alternating mode and every 32 in repetitive mode.
- R10: While `en`=0 both outputs are 0 and the sequence is held at its start. The first bit emitted after `en` returns to 1 is the start of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Generator enable; low clears the outputs and the sequence |
| bit_en | input | 1 | Bit-clock enable; one bit is emitted per enabled edge |
| mode | input | 1 | 1 = alternating words, 0 = repetitive 32-bit pattern |
| pattern | input | 32 | Pattern source; low and high halves are the two words |
| rep_count | input | 8 | Repetitions of each word minus one (alternating mode only) |
| ser_out | output | 1 | Serial pattern bit |
| word_start | output | 1 | High during the first bit of each word |

## Verification
The checker looks at the control behaviour on every cycle. It confirms that the outputs clear on reset, on disable and on a mode change. It confirms that both outputs hold while the bit enable is low. It confirms that word starts fall exactly every 16 or 32 emitted bits. The actual bit values cannot be seen from properties alone: the half order, the count of repetitions (including the 256-repetition case), MSB-first order, the count being ignored in repetitive mode, and sampling at word boundaries. The bench's scenarios show these by comparing every emitted bit against a model of the sequence.

// File: rtl/altword_pkg.sv
package altword_pkg;

    localparam int AW_PAT_W = 32;
    localparam int AW_CNT_W = 8;

    typedef enum logic {
        PM_REPEAT = 1'b0,
        PM_ALT    = 1'b1
    } pat_mode_e;

    function automatic logic mode_is_alt(input logic m);
        return pat_mode_e'(m) == PM_ALT;
    endfunction

endpackage

// File: rtl/altword_seq.sv
module altword_seq #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             adv,
    input  logic             alt_mode,
    input  logic [CNT_W-1:0] rep_count,
    output logic             half
);
    logic [CNT_W-1:0] rep_idx;
    logic             half_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            rep_idx <= '0;
            half_q  <= 1'b0;
        end else if (adv && alt_mode) begin
            if (rep_idx == rep_count) begin
                rep_idx <= '0;
                half_q  <= ~half_q;
            end else begin
                rep_idx <= rep_idx + 1'b1;
            end
        end
    end

    assign half = half_q;
endmodule

// File: rtl/altword_shift.sv
module altword_shift #(
    parameter int PAT_W = 32,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             step,
    input  logic [PAT_W-1:0] load_word,
    input  logic [LEN_W-1:0] load_len,
    output logic             bit_out,
    output logic             first_out,
    output logic             need_load
);
    logic [PAT_W-1:0] sh;
    logic [LEN_W-1:0] left;
    logic             bit_q;
    logic             first_q;

    assign need_load = (left == '0);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            sh      <= '0;
            left    <= '0;
            bit_q   <= 1'b0;
            first_q <= 1'b0;
        end else if (step) begin
            if (need_load) begin
                bit_q   <= load_word[PAT_W-1];
                sh      <= {load_word[PAT_W-2:0], 1'b0};
                left    <= load_len - 1'b1;
                first_q <= 1'b1;
            end else begin
                bit_q   <= sh[PAT_W-1];
                sh      <= {sh[PAT_W-2:0], 1'b0};
                left    <= left - 1'b1;
                first_q <= 1'b0;
            end
        end
    end

    assign bit_out   = bit_q;
    assign first_out = first_q;
endmodule

// File: rtl/altword_gen.sv
module altword_gen
    import altword_pkg::*;
#(
    parameter int PAT_W = AW_PAT_W,
    parameter int CNT_W = AW_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             bit_en,
    input  logic             mode,
    input  logic [PAT_W-1:0] pattern,
    input  logic [CNT_W-1:0] rep_count,
    output logic             ser_out,
    output logic             word_start
);
    localparam int HALF_W = PAT_W / 2;
    localparam int LEN_W  = $clog2(PAT_W + 1);

    logic             mode_q;
    logic             mode_chg;
    logic             restart;
    logic             step;
    logic             adv;
    logic             alt;
    logic             half;
    logic             need_load;
    logic [PAT_W-1:0] load_word;
    logic [LEN_W-1:0] load_len;

    always_ff @(posedge clk) begin
        mode_q <= mode;
    end

    assign mode_chg = (mode != mode_q);
    assign restart  = mode_chg || !en;
    assign step     = en && bit_en && !mode_chg;
    assign adv      = step && need_load;
    assign alt      = mode_is_alt(mode);

    always_comb begin
        if (alt) begin
            load_word = half ? {pattern[PAT_W-1:HALF_W], {HALF_W{1'b0}}}
                             : {pattern[HALF_W-1:0], {HALF_W{1'b0}}};
            load_len  = LEN_W'(HALF_W);
        end else begin
            load_word = pattern;
            load_len  = LEN_W'(PAT_W);
        end
    end

    altword_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .adv       (adv),
        .alt_mode  (alt),
        .rep_count (rep_count),
        .half      (half)
    );

    altword_shift #(.PAT_W(PAT_W), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .step      (step),
        .load_word (load_word),
        .load_len  (load_len),
        .bit_out   (ser_out),
        .first_out (word_start),
        .need_load (need_load)
    );
endmodule

// File: rtl/altword_gen_chk.sv
module altword_gen_chk #(
    parameter int PAT_W = 32
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic bit_en,
    input logic mode,
    input logic ser_out,
    input logic word_start
);
    logic       mode_d;
    logic [6:0] pos;
    logic       emit;
    logic [6:0] wlen;

    assign emit = en && bit_en && (mode == mode_d);
    assign wlen = mode ? 7'(PAT_W / 2) : 7'(PAT_W);

    always_ff @(posedge clk) begin
        mode_d <= mode;
        if (rst || !en || (mode != mode_d)) pos <= '0;
        else if (emit) pos <= (pos == wlen - 1'b1) ? '0 : pos + 1'b1;
    end

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (!ser_out && !word_start)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !bit_en && mode == mode_d) |=> ($stable(ser_out) && $stable(word_start))); // R5

    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (en && mode != mode_d) |=> (!ser_out && !word_start)); // R8

    AST_WORD_START_DUE: assert property (@(posedge clk) disable iff (rst)
        (emit && pos == '0) |=> word_start); // R9

    AST_NO_EXTRA_START: assert property (@(posedge clk) disable iff (rst)
        (emit && pos != '0) |=> !word_start); // R9

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ser_out && !word_start)); // R10
endmodule

bind altword_gen altword_gen_chk #(.PAT_W(PAT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .bit_en     (bit_en),
    .mode       (mode),
    .ser_out    (ser_out),
    .word_start (word_start)
);

// File: tb/altword_gen_test.sv
module altword_gen_test;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        bit_en = 1'b0;
    logic        mode = 1'b1;
    logic [31:0] pattern = '0;
    logic [7:0]  rep_count = '0;
    logic        ser_out;
    logic        word_start;

    int n_tot = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    altword_gen uut (
        .clk(clk), .rst(rst), .en(en), .bit_en(bit_en), .mode(mode),
        .pattern(pattern), .rep_count(rep_count),
        .ser_out(ser_out), .word_start(word_start)
    );

    // {mode, pattern, count, number of bits}
    localparam int NV = 6;
    localparam logic [56:0] VEC [NV] = '{
        {1'b1, 32'hA5C3_0F96, 8'h00, 16'd200},
        {1'b1, 32'h8001_7FFE, 8'h02, 16'd320},
        {1'b0, 32'hDEAD_BEEF, 8'h05, 16'd200},
        {1'b1, 32'h1234_F00D, 8'hFF, 16'd8400},
        {1'b0, 32'hDEAD_BEEF, 8'h00, 16'd100},
        {1'b1, 32'hC001_0BAD, 8'h01, 16'd160}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R3";
            1: return "R2";
            2: return "R6";
            3: return "R3";
            4: return "R6";
            default: return "R4";
        endcase
    endfunction

    function automatic logic exp_bit(input logic m, input logic [31:0] p,
                                     input logic [7:0] c, input int k);
        int wn;
        int bp;
        int per;
        if (!m) return p[31 - (k % 32)];
        wn  = k / 16;
        bp  = k % 16;
        per = 2 * (int'(c) + 1);
        if ((wn % per) >= (int'(c) + 1)) return p[31 - bp];
        return p[15 - bp];
    endfunction

    function automatic logic exp_first(input logic m, input int k);
        return m ? (k % 16 == 0) : (k % 32 == 0);
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%b exp=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "ser_out in reset", ser_out, 1'b0);
        chk("R1", "word_start in reset", word_start, 1'b0);
        rst = 1'b0;
    endtask

    task automatic run_bits(input string req, input int k0, input int n);
        for (int k = k0; k < k0 + n; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(req, "ser_out", ser_out, exp_bit(mode, pattern, rep_count, k));
            chk(req, "word_start", word_start, exp_first(mode, k));
        end
    endtask

    task automatic idle_zero(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(req, "ser_out cleared", ser_out, 1'b0);
            chk(req, "word_start cleared", word_start, 1'b0);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] p1;
        logic [31:0] p2;
        logic        e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "ser_out after reset", ser_out, 1'b0);
        chk("R1", "word_start after reset", word_start, 1'b0);

        // table-driven sequences
        for (int i = 0; i < NV; i++) begin
            mode      = VEC[i][56];
            pattern   = VEC[i][55:24];
            rep_count = VEC[i][23:16];
            en        = 1'b1;
            bit_en    = 1'b1;
            do_reset();
            run_bits(vec_tag(i), 0, int'(VEC[i][15:0]));
        end

        // R1: reset in mid-run restarts at the low word
        mode = 1'b1; pattern = 32'h0F0F_F0F0; rep_count = 8'h01;
        do_reset();
        run_bits("R1", 0, 37);
        do_reset();
        run_bits("R1", 0, 40);

        // R5: bit enable low pauses the stream
        run_bits("R5", 40, 5);
        bit_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R5", "ser_out held", ser_out, exp_bit(mode, pattern, rep_count, 44));
            chk("R5", "word_start held", word_start, exp_first(mode, 44));
        end
        bit_en = 1'b1;
        run_bits("R5", 45, 60);

        // R7: pattern and count changed mid-word
        p1 = 32'hA5C3_0F96; p2 = 32'h3C5A_E718;
        mode = 1'b1; pattern = p1; rep_count = 8'h00;
        do_reset();
        run_bits("R7", 0, 4);
        pattern = p2; rep_count = 8'h01;
        for (int k = 4; k < 80; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k < 16)      e = p1[15 - (k % 16)];
            else if (k < 48) e = p2[31 - (k % 16)];
            else             e = p2[15 - (k % 16)];
            chk("R7", "ser_out", ser_out, e);
            chk("R7", "word_start", word_start, (k % 16) == 0);
        end

        // R8: mode change restarts the sequence
        mode = 1'b1; pattern = 32'h9E37_79B9; rep_count = 8'h00;
        do_reset();
        run_bits("R8", 0, 20);
        mode = 1'b0;
        idle_zero("R8", 1);
        run_bits("R8", 0, 40);
        mode = 1'b1;
        idle_zero("R8", 1);
        run_bits("R8", 0, 40);

        // R10: disable clears and restarts
        en = 1'b0;
        idle_zero("R10", 3);
        en = 1'b1;
        run_bits("R10", 0, 40);

        finish_run();
    end
endmodule